// File: doc/BRIEF.md
# ATA Host Adapter Register Front End

This block sits between a little-endian memory-mapped bus and the task-file logic of an ATA drive. Every bus request carries a 12-bit byte address and an access width of 1, 2 or 4 bytes. The block takes bits [11:4] of the address as a register index, which gives a 4 KB window. It checks whether the register at that index allows the requested width. A legal access to the data port, to a task-file register or to the control/alternate-status register becomes a one-cycle strobe toward the drive. The timing register and the interrupt status register are held inside the block. An illegal access never reaches the drive. A read of that kind answers all ones, and a write of that kind changes nothing.

Two interrupt lines come in: line 0 is the DMA interrupt and line 1 is the drive interrupt. Each line goes straight through to its own output. Each line is also mirrored into one bit of the status word: line n drives bit 31−n. Software acknowledges the DMA bit by writing a one to bit 31.

The sequencing is a three-state machine:
- ST_IDLE: the block is ready for a request.
- ST_DRIVE: the strobe to the drive is active.
- ST_DONE: the response is valid.

It has four transitions:
- IDLE→DRIVE on a legal drive-side access.
- IDLE→DONE on a local or illegal access.
- DRIVE→DONE unconditionally.
- DONE→IDLE unconditionally.

Top module: `ata_regfront`

## Requirements
- R1: The register index is req_addr[11:4]. The low four address bits do not affect decoding.
- R2: Index 0x00 is the data port. It accepts only half (size code 1) and word (size code 2) accesses. Each such access raises drv_data_stb for one cycle. A half read returns the low 16 bits of drv_rdata zero-extended.
- R3: Indices 0x01 to 0x07 are task-file registers and accept only byte accesses (size code 0). Each such access raises drv_tf_stb with drv_tf_idx equal to the index. A read returns drv_rdata[7:0] zero-extended.
- R4: Indices 0x08 and 0x16 both select the control register and accept byte accesses only. A read raises drv_ctl_stb and returns the alternate status byte. A write raises drv_ctl_stb with drv_we high and drv_wdata equal to the bus data.
- R5: Index 0x20 is a 32-bit timing register. It is written and read back only with word accesses.
- R6: A word read of index 0x30 returns the interrupt status word. Bit 31 follows the DMA line and bit 30 follows the drive line, updating on every change of level. All other bits read 0.
- R7: A word write to index 0x30 with bit 31 set clears bit 31 and leaves bit 30 unchanged. A write with bit 31 clear has no effect. If the DMA line changes level in the same cycle, the line change takes priority over the clear.
- R8: A read of an unmapped index, a read with a width the register does not allow, or a read with size code 3 returns 0xFFFFFFFF and raises no drive strobe.
- R9: A write of the kinds listed in R8 raises no drive strobe and leaves the timing and interrupt registers unchanged.
- R10: After reset, req_ready is 1, rsp_valid is 0, all strobes are 0, and the timing and interrupt status registers read 0.
- R11: dma_irq_out equals dma_irq_in and drv_irq_out equals drv_irq_in at all times.
- R12: The block accepts a request only when req_ready is high. rsp_valid rises one cycle after acceptance for local or illegal accesses and two cycles after acceptance for drive accesses. At most one drive strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_ready | output | 1 | Block idle, request accepted |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_rdata | output | 32 | Read data |
| drv_data_stb | output | 1 | Data port strobe |
| drv_tf_stb | output | 1 | Task-file register strobe |
| drv_ctl_stb | output | 1 | Control / alternate status strobe |
| drv_we | output | 1 | Strobe is a write |
| drv_tf_idx | output | 3 | Task-file register number |
| drv_size | output | 2 | Width code of the strobed access |
| drv_wdata | output | 32 | Write data to the drive |
| drv_rdata | input | 32 | Read data from the drive, valid during a strobe |
| dma_irq_in | input | 1 | DMA interrupt level |
| drv_irq_in | input | 1 | Drive interrupt level |
| dma_irq_out | output | 1 | DMA interrupt forwarded |
| drv_irq_out | output | 1 | Drive interrupt forwarded |

## Verification
A wrong decode or width check appears in the very first response. The bench sees either a strobe that should not be there or a missing strobe during the ST_DRIVE cycle. It also sees an all-ones word or a drive word where the other was due, in the ST_DONE cycle that follows. A stuck state machine shows up as a response latency other than one or two cycles. A corrupted interrupt status bit stays hidden until the next word read of index 0x30. For that reason, every line change and every clear write in the bench is followed directly by such a read. A timing-register fault is caught by a read-back right after a legal write and right after an illegal write.

// File: rtl/ata_regfront_pkg.sv
package ata_regfront_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_DATA   = 3'd1,
        TGT_TASK   = 3'd2,
        TGT_CTRL   = 3'd3,
        TGT_TIMING = 3'd4,
        TGT_IRQ    = 3'd5
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_DONE  = 2'd2
    } fsm_e;

    localparam int IDX_DATA   = 'h00;
    localparam int IDX_TF_LO  = 'h01;
    localparam int IDX_TF_HI  = 'h07;
    localparam int IDX_CTRL_A = 'h08;
    localparam int IDX_CTRL_B = 'h16;
    localparam int IDX_TIMING = 'h20;
    localparam int IDX_IRQ    = 'h30;

    localparam int IDX_SHIFT  = 4;

endpackage

// File: rtl/ata_addr_decode.sv
module ata_addr_decode
    import ata_regfront_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output tgt_e             tgt
);

    acc_size_e sz;
    logic      is_tf;

    assign sz    = acc_size_e'(size);
    assign is_tf = (idx >= IDX_W'(IDX_TF_LO)) && (idx <= IDX_W'(IDX_TF_HI));

    always_comb begin
        tgt = TGT_NONE;
        if (idx == IDX_W'(IDX_DATA)) begin
            if (sz == SZ_HALF || sz == SZ_WORD) tgt = TGT_DATA;
        end else if (is_tf) begin
            if (sz == SZ_BYTE) tgt = TGT_TASK;
        end else if (idx == IDX_W'(IDX_CTRL_A) || idx == IDX_W'(IDX_CTRL_B)) begin
            if (sz == SZ_BYTE) tgt = TGT_CTRL;
        end else if (idx == IDX_W'(IDX_TIMING)) begin
            if (sz == SZ_WORD) tgt = TGT_TIMING;
        end else if (idx == IDX_W'(IDX_IRQ)) begin
            if (sz == SZ_WORD) tgt = TGT_IRQ;
        end
    end

endmodule

// File: rtl/ata_irq_status.sv
module ata_irq_status #(
    parameter int DATA_W = 32,
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_in,
    input  logic              clr_top,
    output logic [DATA_W-1:0] stat,
    output logic [NLINES-1:0] line_out
);

    localparam int TOP = DATA_W - 1;

    logic [NLINES-1:0] prev_q;
    logic [NLINES-1:0] bit_q;

    assign line_out = line_in;

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        // line n owns status bit (TOP - n); only line 0 can be cleared by software
        logic clr_this;
        if (n == 0) begin : g_clr
            assign clr_this = clr_top;
        end else begin : g_noclr
            assign clr_this = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[n] <= 1'b0;
                bit_q[n]  <= 1'b0;
            end else begin
                prev_q[n] <= line_in[n];
                if (line_in[n] != prev_q[n]) begin
                    bit_q[n] <= line_in[n];
                end else if (clr_this) begin
                    bit_q[n] <= 1'b0;
                end
            end
        end

        assign stat[TOP-n] = bit_q[n];
    end

    assign stat[TOP-NLINES:0] = '0;

endmodule

// File: rtl/ata_timing_reg.sv
module ata_timing_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end
    end

endmodule

// File: rtl/ata_regfront.sv
module ata_regfront
    import ata_regfront_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              drv_data_stb,
    output logic              drv_tf_stb,
    output logic              drv_ctl_stb,
    output logic              drv_we,
    output logic [2:0]        drv_tf_idx,
    output logic [1:0]        drv_size,
    output logic [DATA_W-1:0] drv_wdata,
    input  logic [DATA_W-1:0] drv_rdata,
    input  logic              dma_irq_in,
    input  logic              drv_irq_in,
    output logic              dma_irq_out,
    output logic              drv_irq_out
);

    localparam int IDX_W  = ADDR_W - IDX_SHIFT;
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = 8;

    fsm_e              state_q, state_d;
    tgt_e              dec_tgt;
    tgt_e              lat_tgt;
    logic              lat_write;
    logic [1:0]        lat_size;
    logic [2:0]        lat_idx;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] rsp_q;
    logic [DATA_W-1:0] timing_val;
    logic [DATA_W-1:0] irq_stat;
    logic [1:0]        irq_lines_out;
    logic              accept;
    logic              drive_side;
    logic              timing_we;
    logic              irq_clr;
    logic [DATA_W-1:0] drv_masked;

    ata_addr_decode #(.IDX_W(IDX_W)) u_dec (
        .idx  (req_addr[ADDR_W-1:IDX_SHIFT]),
        .size (req_size),
        .tgt  (dec_tgt)
    );

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign drive_side = (dec_tgt == TGT_DATA) || (dec_tgt == TGT_TASK) || (dec_tgt == TGT_CTRL);
    assign timing_we  = accept && req_write && (dec_tgt == TGT_TIMING);
    assign irq_clr    = accept && req_write && (dec_tgt == TGT_IRQ) && req_wdata[DATA_W-1];

    ata_timing_reg #(.DATA_W(DATA_W)) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (timing_we),
        .wr_data (req_wdata),
        .value   (timing_val)
    );

    ata_irq_status #(.DATA_W(DATA_W), .NLINES(2)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  ({drv_irq_in, dma_irq_in}),
        .clr_top  (irq_clr),
        .stat     (irq_stat),
        .line_out (irq_lines_out)
    );

    assign dma_irq_out = irq_lines_out[0];
    assign drv_irq_out = irq_lines_out[1];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = drive_side ? ST_DRIVE : ST_DONE;
            ST_DRIVE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // drive-side read data trimmed to the access width
    always_comb begin
        unique case (acc_size_e'(lat_size))
            SZ_BYTE: drv_masked = {{(DATA_W-BYTE_W){1'b0}}, drv_rdata[BYTE_W-1:0]};
            SZ_HALF: drv_masked = {{(DATA_W-HALF_W){1'b0}}, drv_rdata[HALF_W-1:0]};
            default: drv_masked = drv_rdata;
        endcase
    end

    // request latch and response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_tgt   <= TGT_NONE;
            lat_write <= 1'b0;
            lat_size  <= 2'd0;
            lat_idx   <= 3'd0;
            lat_wdata <= '0;
            rsp_q     <= '0;
        end else if (accept) begin
            lat_tgt   <= dec_tgt;
            lat_write <= req_write;
            lat_size  <= req_size;
            lat_idx   <= req_addr[IDX_SHIFT+2:IDX_SHIFT];
            lat_wdata <= req_wdata;
            if (req_write) begin
                rsp_q <= '0;
            end else begin
                unique case (dec_tgt)
                    TGT_TIMING: rsp_q <= timing_val;
                    TGT_IRQ:    rsp_q <= irq_stat;
                    TGT_NONE:   rsp_q <= '1;
                    default:    rsp_q <= '0;
                endcase
            end
        end else if (state_q == ST_DRIVE && !lat_write) begin
            rsp_q <= drv_masked;
        end
    end

    // outputs per state
    always_comb begin
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        drv_data_stb = 1'b0;
        drv_tf_stb   = 1'b0;
        drv_ctl_stb  = 1'b0;
        drv_we       = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_DRIVE: begin
                drv_data_stb = (lat_tgt == TGT_DATA);
                drv_tf_stb   = (lat_tgt == TGT_TASK);
                drv_ctl_stb  = (lat_tgt == TGT_CTRL);
                drv_we       = lat_write;
            end
            ST_DONE:  rsp_valid = 1'b1;
            default:  ;
        endcase
    end

    assign rsp_rdata  = rsp_q;
    assign drv_tf_idx = lat_idx;
    assign drv_size   = lat_size;
    assign drv_wdata  = lat_wdata;

endmodule

// File: rtl/ata_regfront_chk.sv
module ata_regfront_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              drv_data_stb,
    input logic              drv_tf_stb,
    input logic              drv_ctl_stb,
    input logic [2:0]        drv_tf_idx,
    input logic              dma_irq_in,
    input logic              drv_irq_in,
    input logic [DATA_W-1:0] irq_stat
);

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_data_stb, drv_tf_stb, drv_ctl_stb}));

    a_r12_rsp_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r12_rsp_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    a_r3_tf_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        drv_tf_stb |-> (drv_tf_idx != 3'd0));

    a_r6_dma_bit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_irq_in) |=> irq_stat[DATA_W-1]);

    a_r6_drv_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_irq_in) |=> !irq_stat[DATA_W-2]);

    a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat[DATA_W-3:0] == '0);

endmodule

bind ata_regfront ata_regfront_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .drv_data_stb (drv_data_stb),
    .drv_tf_stb   (drv_tf_stb),
    .drv_ctl_stb  (drv_ctl_stb),
    .drv_tf_idx   (drv_tf_idx),
    .dma_irq_in   (dma_irq_in),
    .drv_irq_in   (drv_irq_in),
    .irq_stat     (irq_stat)
);

// File: tb/ata_regfront_test.sv
module ata_regfront_test;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;
    localparam int NVEC = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        drv_data_stb, drv_tf_stb, drv_ctl_stb, drv_we;
    logic [2:0]  drv_tf_idx;
    logic [1:0]  drv_size;
    logic [31:0] drv_wdata;
    logic [31:0] drv_rdata;
    logic        dma_irq_in = 1'b0;
    logic        drv_irq_in = 1'b0;
    logic        dma_irq_out, drv_irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // drive-side model
    always_comb begin
        if (drv_data_stb)     drv_rdata = 32'h1234_ABCD;
        else if (drv_tf_stb)  drv_rdata = {24'hEEEEEE, 5'd0, drv_tf_idx};
        else if (drv_ctl_stb) drv_rdata = 32'hFFFF_FF58;
        else                  drv_rdata = 32'hDEAD_BEEF;
    end

    ata_regfront uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .drv_data_stb(drv_data_stb), .drv_tf_stb(drv_tf_stb), .drv_ctl_stb(drv_ctl_stb),
        .drv_we(drv_we), .drv_tf_idx(drv_tf_idx), .drv_size(drv_size),
        .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
        .dma_irq_in(dma_irq_in), .drv_irq_in(drv_irq_in),
        .dma_irq_out(dma_irq_out), .drv_irq_out(drv_irq_out)
    );

    // {wr, addr[11:0], size[1:0], wdata[31:0], exp_rdata[31:0], exp_stb{data,tf,ctl}}
    localparam logic [81:0] VEC [NVEC] = '{
        {1'b0, 12'h000, 2'd2, 32'h0,         32'h1234ABCD, 3'b100}, // R2 word
        {1'b0, 12'h004, 2'd1, 32'h0,         32'h0000ABCD, 3'b100}, // R2 half, R1 low bits
        {1'b0, 12'h000, 2'd0, 32'h0,         32'hFFFFFFFF, 3'b000}, // R8 byte on data
        {1'b0, 12'h030, 2'd0, 32'h0,         32'h00000003, 3'b010}, // R3
        {1'b0, 12'h07F, 2'd0, 32'h0,         32'h00000007, 3'b010}, // R3, R1
        {1'b0, 12'h010, 2'd2, 32'h0,         32'hFFFFFFFF, 3'b000}, // R8 word on tf
        {1'b0, 12'h080, 2'd0, 32'h0,         32'h00000058, 3'b001}, // R4 alias A
        {1'b0, 12'h160, 2'd0, 32'h0,         32'h00000058, 3'b001}, // R4 alias B
        {1'b0, 12'h080, 2'd2, 32'h0,         32'hFFFFFFFF, 3'b000}, // R8 word on ctl
        {1'b0, 12'h090, 2'd0, 32'h0,         32'hFFFFFFFF, 3'b000}, // R8 unmapped
        {1'b1, 12'h200, 2'd2, 32'h0BADF00D,  32'h0,        3'b000}, // R5 write
        {1'b0, 12'h200, 2'd2, 32'h0,         32'h0BADF00D, 3'b000}, // R5 readback
        {1'b1, 12'h200, 2'd1, 32'h11112222,  32'h0,        3'b000}, // R9 bad width
        {1'b0, 12'h20C, 2'd2, 32'h0,         32'h0BADF00D, 3'b000}, // R9 unchanged
        {1'b0, 12'h200, 2'd0, 32'h0,         32'hFFFFFFFF, 3'b000}, // R8 byte on timing
        {1'b1, 12'h050, 2'd0, 32'h0000005A,  32'h0,        3'b010}, // R3 write
        {1'b1, 12'h000, 2'd0, 32'h000000A5,  32'h0,        3'b000}, // R9 byte data write
        {1'b0, 12'hFF0, 2'd2, 32'h0,         32'hFFFFFFFF, 3'b000}, // R8 top of window
        {1'b0, 12'h000, 2'd3, 32'h0,         32'hFFFFFFFF, 3'b000}, // R8 reserved size
        {1'b1, 12'h088, 2'd0, 32'h00000004,  32'h0,        3'b001}, // R4 control write
        {1'b1, 12'h400, 2'd2, 32'hFFFFFFFF,  32'h0,        3'b000}  // R9 unmapped write
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic [2:0] stb, output int lat,
                          output logic we_seen, output logic [31:0] wd_seen);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; stb = 3'b000; we_seen = 1'b0; wd_seen = '0;
        while (!rsp_valid) begin
            stb = stb | {drv_data_stb, drv_tf_stb, drv_ctl_stb};
            if (drv_data_stb || drv_tf_stb || drv_ctl_stb) begin
                we_seen = drv_we; wd_seen = drv_wdata;
            end
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
    endtask

    task automatic rd_word(input logic [11:0] a, output logic [31:0] rd);
        logic [2:0] s; int l; logic w; logic [31:0] d;
        do_acc(1'b0, a, 2'd2, 32'h0, rd, s, l, w, d);
    endtask

    task automatic wr_word(input logic [11:0] a, input logic [31:0] v);
        logic [31:0] r; logic [2:0] s; int l; logic w; logic [31:0] d;
        do_acc(1'b1, a, 2'd2, v, r, s, l, w, d);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_LIMIT) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_LIMIT);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd, wdseen;
        logic [2:0]  stb;
        int          lat;
        logic        we;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 req_ready", {31'd0, req_ready}, 32'd1);
        check("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R10 strobes", {29'd0, drv_data_stb, drv_tf_stb, drv_ctl_stb}, 32'd0);
        rd_word(12'h200, rd); check("R10 timing", rd, 32'h0);
        rd_word(12'h300, rd); check("R10 irq status", rd, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [81:0] v;
            v = VEC[i];
            do_acc(v[81], v[80:69], v[68:67], v[66:35], rd, stb, lat, we, wdseen);
            check($sformatf("R1/R2/R3/R4/R8/R9 vec%0d strobes", i), {29'd0, stb}, {29'd0, v[2:0]});
            check($sformatf("R12 vec%0d latency", i), lat, (v[2:0] != 3'b000) ? 2 : 1);
            if (!v[81]) begin
                check($sformatf("R2/R3/R4/R5/R8 vec%0d rdata", i), rd, v[34:3]);
            end else if (v[2:0] != 3'b000) begin
                check($sformatf("R3/R4 vec%0d drv_we", i), {31'd0, we}, 32'd1);
                check($sformatf("R3/R4 vec%0d drv_wdata", i), wdseen, v[66:35]);
            end
        end

        // R11 pass-through and R6 mirroring
        @(negedge clk); dma_irq_in = 1'b1;
        #1 check("R11 dma out", {31'd0, dma_irq_out}, 32'd1);
        rd_word(12'h300, rd); check("R6 dma bit set", rd, 32'h8000_0000);
        @(negedge clk); drv_irq_in = 1'b1;
        #1 check("R11 drv out", {31'd0, drv_irq_out}, 32'd1);
        rd_word(12'h300, rd); check("R6 both bits", rd, 32'hC000_0000);
        // R7 clear by writing bit 31
        wr_word(12'h300, 32'h8000_0000);
        rd_word(12'h300, rd); check("R7 clear dma bit", rd, 32'h4000_0000);
        // re-arm via a level change, then a write without bit 31
        @(negedge clk); dma_irq_in = 1'b0;
        @(negedge clk); dma_irq_in = 1'b1;
        rd_word(12'h300, rd); check("R6 re-arm", rd, 32'hC000_0000);
        wr_word(12'h300, 32'h4000_0000);
        rd_word(12'h300, rd); check("R7 no-op write", rd, 32'hC000_0000);
        // illegal width on interrupt register does not clear (R9)
        begin
            do_acc(1'b1, 12'h300, 2'd0, 32'h8000_0080, rd, stb, lat, we, wdseen);
        end
        rd_word(12'h300, rd); check("R9 byte write irq", rd, 32'hC000_0000);
        @(negedge clk); drv_irq_in = 1'b0;
        #1 check("R11 drv out low", {31'd0, drv_irq_out}, 32'd0);
        rd_word(12'h300, rd); check("R6 drv bit clears", rd, 32'h8000_0000);
        @(negedge clk); dma_irq_in = 1'b0;
        rd_word(12'h300, rd); check("R6 dma bit clears", rd, 32'h0);

        // R10 reset mid-run
        wr_word(12'h200, 32'h0000_0077);
        rd_word(12'h200, rd); check("R5 before reset", rd, 32'h77);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_word(12'h200, rd); check("R10 timing after reset", rd, 32'h0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule